// File: doc/BRIEF.md
# Configurable SPI Byte Shift Engine

This block moves one byte at a time over a four-wire SPI link, full duplex, in either the master or the slave role. A small register window configures the role, clock polarity, clock phase, bit order and the master clock divider. Software writes the outgoing byte there and reads the byte that came back. When a byte finishes, a completion flag is raised. The flag stays set until software clears it, and it can be routed to an interrupt line.

In master mode, a write of the outgoing byte starts a transfer. The engine pulls its select output low and produces sixteen clock edges, each half period lasting N+1 system clocks. In slave mode, the pins from the remote master are passed through a two-stage synchroniser and their edges are detected in the system clock domain. With phase 0, the select line frames the byte. With phase 1, the byte starts at the first clock edge after select goes low.

The controller has five named states:
- IDLE
- M_RUN: master shifting
- S_WAIT: slave armed, waiting for the first clock edge
- S_SHIFT: slave shifting
- S_DONE: slave byte complete, waiting for select to rise

The named transitions are:
- start: IDLE to M_RUN
- select-fall: IDLE to S_SHIFT with phase 0, or IDLE to S_WAIT with phase 1
- first-edge: S_WAIT to S_SHIFT
- last-edge: M_RUN to IDLE
- eighth-sample: S_SHIFT to S_DONE
- abort: S_SHIFT or S_WAIT to IDLE when select rises
- release: S_DONE to IDLE when select rises

Top module: `sbp_top`

## Requirements
- R1: After reset, all four registers read 0, `irq` is 0, `ss_n_o` is 1 and `sck_o` is 0. The register addresses are: 0 control, 1 divider, 2 data, 3 status. The control bits are: bit0 master, bit1 polarity, bit2 phase, bit3 LSB-first, bit4 interrupt enable. Status bit0 is the completion flag.
- R2: In master mode (control bit0 = 1), writing address 2 starts a transfer. `ss_n_o` is driven low, `sck_o` makes 16 edges, the byte goes out on `sdo` and a byte is taken in from `sdi`. The received byte reads back at address 2. `ss_n_o` returns to 1 at the end.
- R3: `sck_o` rests at the polarity bit (0 low, 1 high) before and after a master transfer.
- R4: Every half period of `sck_o` lasts N+1 system clocks, where N is the divider register.
- R5: With phase 0, data is sampled on the leading (first) edge of each clock cycle and changes on the trailing edge. The first bit is valid before the first edge.
- R6: With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R7: Control bit3 = 1 shifts bit 0 first on both `sdo` and `sdi`. Control bit3 = 0 shifts bit 7 first.
- R8: The completion flag sets when a byte completes and holds until any write to address 3. `irq` equals the flag ANDed with control bit4.
- R9: Writes to addresses 0, 1 and 2 while a transfer is in progress are ignored.
- R10: In slave mode with phase 0, the first bit appears on `sdo` once `ss_n_i` falls, before any clock edge. The flag sets only after `ss_n_i` rises following eight samples.
- R11: In slave mode with phase 1, the transfer begins at the first `sck_i` edge. The flag sets after the eighth trailing edge, while `ss_n_i` is still low.
- R12: If `ss_n_i` rises before eight samples, the slave transfer aborts without setting the flag. The next transfer starts again from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| sck_i | input | 1 | Serial clock from a remote master (slave mode) |
| ss_n_i | input | 1 | Active-low select from a remote master (slave mode) |
| sdi | input | 1 | Serial data in (master: from slave; slave: from master) |
| sck_o | output | 1 | Serial clock generated in master mode |
| ss_n_o | output | 1 | Active-low select driven in master mode |
| sdo | output | 1 | Serial data out |

## Verification
In master mode, the engine enters M_RUN two clocks after the data write. Its first clock edge follows N+1 clocks later. The flag becomes readable two clocks after the sixteenth edge, so the bench detects each edge at the falling system-clock edge, counts the clocks between edges, and reads status only after that two-clock delay. In slave mode, each pin event reaches the engine three clocks after the bench changes the pin, and the flag follows two clocks later. The bench therefore holds every slave half period for eight clocks and waits six clocks before it reads status. Outputs are sampled away from the active edge, and every expected byte is rebuilt bit by bit from the configured order.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_DIV  = 2'd1,
        A_DATA = 2'd2,
        A_STAT = 2'd3
    } addr_e;

    typedef struct packed {
        logic irq_en;
        logic lsb_first;
        logic cpha;
        logic cpol;
        logic master;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_M_RUN,
        ST_S_WAIT,
        ST_S_SHIFT,
        ST_S_DONE
    } state_e;
endpackage

// File: rtl/sbp_sync.sv
module sbp_sync #(
    parameter int unsigned         WIDTH   = 3,
    parameter int unsigned         STAGES  = 2,
    parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sbp_clkgen.sv
module sbp_clkgen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: with a nonzero divider two half-period ticks never touch
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/sbp_regs.sv
module sbp_regs
    import sbp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] rx_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] div_o,
    output logic [DATA_W-1:0] tx_o,
    output logic              start_o,
    output logic              irq_o
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] div_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              flag_q;
    logic              start_q;
    logic              lock;
    logic              wr_ok;

    assign lock  = busy_i || start_q;
    assign wr_ok = wr_i && !lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            div_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            flag_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= wr_ok && (addr_i == A_DATA) && ctrl_q.master;
            if (wr_ok && addr_i == A_CTRL) begin
                ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
            end
            if (wr_ok && addr_i == A_DIV) begin
                div_q <= wdata_i;
            end
            if (wr_ok && addr_i == A_DATA) begin
                tx_q <= wdata_i;
            end
            if (done_i) begin
                flag_q <= 1'b1;
                rx_q   <= rx_i;
            end else if (wr_i && addr_i == A_STAT) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_e'(addr_i))
            A_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
            A_DIV:   rdata_o = div_q;
            A_DATA:  rdata_o = rx_q;
            A_STAT:  rdata_o[0] = flag_q;
            default: rdata_o = '0;
        endcase
    end

    assign ctrl_o  = ctrl_q;
    assign div_o   = div_q;
    assign tx_o    = tx_q;
    assign start_o = start_q;
    assign irq_o   = flag_q && ctrl_q.irq_en;

    // R8: the flag only rises one cycle after the engine reports completion
    p_flag_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(done_i));

    // R9: configuration and outgoing byte are frozen while the engine is busy
    p_locked_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(ctrl_q) && $stable(div_q) && $stable(tx_q)));
endmodule

// File: rtl/sbp_shifter.sv
module sbp_shifter
    import sbp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              lsb_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] tx_i,
    input  logic              tick_i,
    input  logic              sck_s_i,
    input  logic              ss_n_s_i,
    input  logic              sdi_s_i,
    input  logic              sdi_raw_i,
    output logic              run_o,
    output logic              sck_o,
    output logic              ss_n_o,
    output logic              sdo_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_o
);
    localparam int unsigned         CNT_W     = $clog2(2 * DATA_W);
    localparam logic [CNT_W-1:0]    LAST_EDGE = CNT_W'(2 * DATA_W - 1);
    localparam logic [CNT_W-1:0]    LAST_PAIR = CNT_W'(2 * DATA_W - 2);

    state_e            state_q, state_d;
    logic [CNT_W-1:0]  edge_cnt_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic              sdo_q;
    logic              sck_q;
    logic              ss_q;
    logic              done_q;
    logic              sck_prev_q;
    logic              ss_prev_q;

    logic sck_chg, ss_fall, ss_rise;
    logic ev_edge, is_lead, is_last, sample_ev, drive_ev, samp_last;
    logic din, done_d, launch;

    function automatic logic pick_bit(input logic [DATA_W-1:0] v, input logic lsb);
        return lsb ? v[0] : v[DATA_W-1];
    endfunction

    function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] v, input logic lsb);
        return lsb ? (v >> 1) : (v << 1);
    endfunction

    // event decode
    assign sck_chg   = (sck_s_i != sck_prev_q);
    assign ss_fall   = ss_prev_q && !ss_n_s_i;
    assign ss_rise   = !ss_prev_q && ss_n_s_i;
    assign ev_edge   = ((state_q == ST_M_RUN) && tick_i) ||
                       (((state_q == ST_S_WAIT) || (state_q == ST_S_SHIFT)) && sck_chg);
    assign is_lead   = !edge_cnt_q[0];
    assign is_last   = (edge_cnt_q == LAST_EDGE);
    assign sample_ev = ev_edge && (cpha_i ? !is_lead : is_lead);
    assign drive_ev  = ev_edge && (cpha_i ? is_lead : (!is_lead && !is_last));
    assign samp_last = sample_ev && (edge_cnt_q >= LAST_PAIR);
    assign din       = master_i ? sdi_raw_i : sdi_s_i;
    assign launch    = (state_q == ST_IDLE) && (state_d != ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (master_i && start_i) begin
                    state_d = ST_M_RUN;
                end else if (!master_i && ss_fall) begin
                    state_d = cpha_i ? ST_S_WAIT : ST_S_SHIFT;
                end
            end
            ST_M_RUN: begin
                if (tick_i && is_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_S_WAIT: begin
                if (ss_rise) begin
                    state_d = ST_IDLE;
                end else if (sck_chg) begin
                    state_d = ST_S_SHIFT;
                end
            end
            ST_S_SHIFT: begin
                if (ss_rise) begin
                    state_d = ST_IDLE;
                end else if (samp_last) begin
                    state_d = ST_S_DONE;
                end
            end
            ST_S_DONE: begin
                if (ss_rise) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign done_d = ((state_q == ST_M_RUN) && tick_i && is_last) ||
                    ((state_q == ST_S_SHIFT) && !ss_rise && samp_last && cpha_i) ||
                    ((state_q == ST_S_DONE) && ss_rise && !cpha_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt_q <= '0;
            tx_sh_q    <= '0;
            rx_sh_q    <= '0;
            sdo_q      <= 1'b0;
            sck_q      <= 1'b0;
            ss_q       <= 1'b1;
            done_q     <= 1'b0;
            sck_prev_q <= 1'b0;
            ss_prev_q  <= 1'b1;
        end else begin
            done_q     <= done_d;
            sck_prev_q <= sck_s_i;
            ss_prev_q  <= ss_n_s_i;
            ss_q       <= (state_d != ST_M_RUN);
            if (state_q == ST_IDLE) begin
                sck_q <= cpol_i;
            end else if ((state_q == ST_M_RUN) && tick_i) begin
                sck_q <= ~sck_q;
            end
            if (launch) begin
                edge_cnt_q <= '0;
                if (!cpha_i) begin
                    sdo_q   <= pick_bit(tx_i, lsb_i);
                    tx_sh_q <= advance(tx_i, lsb_i);
                end else begin
                    tx_sh_q <= tx_i;
                end
            end else if (ev_edge) begin
                edge_cnt_q <= edge_cnt_q + 1'b1;
                if (sample_ev) begin
                    rx_sh_q <= lsb_i ? {din, rx_sh_q[DATA_W-1:1]}
                                     : {rx_sh_q[DATA_W-2:0], din};
                end
                if (drive_ev) begin
                    sdo_q   <= pick_bit(tx_sh_q, lsb_i);
                    tx_sh_q <= advance(tx_sh_q, lsb_i);
                end
            end
        end
    end

    assign run_o  = (state_q == ST_M_RUN);
    assign sck_o  = sck_q;
    assign ss_n_o = ss_q;
    assign sdo_o  = sdo_q;
    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign rx_o   = rx_sh_q;

    // R8: completion is a single-cycle event
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R3: after the sixteenth edge the clock is back at rest and select released
    p_master_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_M_RUN && state_q == ST_IDLE) |-> (ss_n_o && sck_q == cpol_i));

    // R12: select rising in mid-byte produces no completion
    p_abort_no_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S_SHIFT && ss_rise) |=> !done_q);
endmodule

// File: rtl/sbp_top.sv
module sbp_top
    import sbp_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              sdi,
    output logic              sck_o,
    output logic              ss_n_o,
    output logic              sdo
);
    localparam int unsigned DIV_W = DATA_W;

    ctrl_t             ctrl;
    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] tx_byte;
    logic [DATA_W-1:0] rx_byte;
    logic              start, busy, done, tick, run;
    logic [2:0]        pins_s;

    sbp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr),
        .wr_i    (reg_wr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .busy_i  (busy),
        .done_i  (done),
        .rx_i    (rx_byte),
        .ctrl_o  (ctrl),
        .div_o   (div),
        .tx_o    (tx_byte),
        .start_o (start),
        .irq_o   (irq)
    );

    sbp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sdi, ss_n_i, sck_i}),
        .q     (pins_s)
    );

    sbp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (div),
        .tick_o (tick)
    );

    sbp_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_i  (ctrl.master),
        .cpol_i    (ctrl.cpol),
        .cpha_i    (ctrl.cpha),
        .lsb_i     (ctrl.lsb_first),
        .start_i   (start),
        .tx_i      (tx_byte),
        .tick_i    (tick),
        .sck_s_i   (pins_s[0]),
        .ss_n_s_i  (pins_s[1]),
        .sdi_s_i   (pins_s[2]),
        .sdi_raw_i (sdi),
        .run_o     (run),
        .sck_o     (sck_o),
        .ss_n_o    (ss_n_o),
        .sdo_o     (sdo),
        .busy_o    (busy),
        .done_o    (done),
        .rx_o      (rx_byte)
    );
endmodule

// File: tb/sbp_top_bench.sv
module sbp_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       sck_i = 1'b0;
    logic       ss_n_i = 1'b1;
    logic       sdi = 1'b0;
    logic       sck_o, ss_n_o, sdo;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbp_top u_sbp_top (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sck_i(sck_i), .ss_n_i(ss_n_i), .sdi(sdi),
        .sck_o(sck_o), .ss_n_o(ss_n_o), .sdo(sdo)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic bit_of(input logic [7:0] b, input int k, input logic lsb);
        return lsb ? b[k] : b[7-k];
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // R1
    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), v);
            check("R1", "register after reset", v, 8'h00);
        end
        check("R1", "irq after reset", irq, 1'b0);
        check("R1", "ss_n_o after reset", ss_n_o, 1'b1);
        check("R1", "sck_o after reset", sck_o, 1'b0);
    endtask

    task automatic t_master(input string req, input logic cpol, input logic cpha, input logic lsb,
                            input logic ien, input logic [7:0] div, input logic [7:0] tx,
                            input logic [7:0] pat, input bit inj);
        logic [7:0] cfg, seen, v;
        int edges, since, guard;
        logic prev;
        bit half_bad;
        cfg = {3'b000, ien, lsb, cpha, cpol, 1'b1};
        reg_write(2'd0, cfg);
        reg_write(2'd1, div);
        @(negedge clk);
        check("R3", "sck_o rest before transfer", sck_o, cpol);
        sdi = cpha ? 1'b0 : bit_of(pat, 0, lsb);
        reg_write(2'd2, tx);
        seen = '0; edges = 0; since = 0; guard = 0; prev = cpol; half_bad = 0;
        while (edges < 16 && guard < 20000) begin
            @(negedge clk);
            guard++; since++;
            if (sck_o !== prev) begin
                edges++;
                prev = sck_o;
                if (edges == 1) check("R2", "ss_n_o low in transfer", ss_n_o, 1'b0);
                if (edges > 1 && since != int'(div) + 1) half_bad = 1;
                since = 0;
                if ((edges % 2 == 1) != cpha) begin
                    seen[lsb ? (edges-1)/2 : 7-(edges-1)/2] = sdo;
                end else if (cpha) begin
                    sdi = bit_of(pat, (edges-1)/2, lsb);
                end else if (edges/2 < 8) begin
                    sdi = bit_of(pat, edges/2, lsb);
                end
                if (inj && edges == 5) begin
                    reg_write(2'd2, ~tx);
                    since += 2;
                end
                if (inj && edges == 9) begin
                    reg_write(2'd0, 8'h00);
                    since += 2;
                end
            end
        end
        check(req, "edge count", edges, 16);
        check("R4", "half period equals divider+1", half_bad, 1'b0);
        check("R3", "sck_o rest after transfer", sck_o, cpol);
        @(negedge clk);
        @(negedge clk);
        check("R2", "ss_n_o released", ss_n_o, 1'b1);
        reg_read(2'd3, v);
        check("R8", "flag after byte", v, 8'h01);
        check("R8", "irq gated by enable", irq, ien);
        reg_read(2'd2, v);
        check(req, "received byte", v, pat);
        check(req, "transmitted byte", seen, tx);
        if (inj) begin
            reg_read(2'd0, v);
            check("R9", "control unchanged by busy write", v, cfg);
        end
        reg_write(2'd3, 8'h00);
        reg_read(2'd3, v);
        check("R8", "flag cleared by status write", v, 8'h00);
        check("R8", "irq low after clear", irq, 1'b0);
    endtask

    task automatic t_slave(input string req, input logic cpol, input logic cpha, input logic lsb,
                           input logic [7:0] tx, input logic [7:0] pat, input int nbits);
        logic [7:0] seen, v;
        seen = '0;
        reg_write(2'd0, {3'b000, 1'b1, lsb, cpha, cpol, 1'b0});
        reg_write(2'd2, tx);
        sck_i = cpol; ss_n_i = 1'b1; sdi = 1'b0;
        repeat (H) @(negedge clk);
        ss_n_i = 1'b0;
        if (!cpha) sdi = bit_of(pat, 0, lsb);
        repeat (H) @(negedge clk);
        if (!cpha) check("R10", "first bit before any edge", sdo, bit_of(tx, 0, lsb));
        for (int k = 0; k < nbits; k++) begin
            sck_i = ~cpol;
            if (cpha) sdi = bit_of(pat, k, lsb);
            repeat (H) @(negedge clk);
            seen[lsb ? k : 7-k] = sdo;
            sck_i = cpol;
            if (!cpha && k < 7) sdi = bit_of(pat, k+1, lsb);
            repeat (H) @(negedge clk);
        end
        if (nbits == 8) begin
            reg_read(2'd3, v);
            if (cpha) check("R11", "flag while select low", v, 8'h01);
            else      check("R10", "no flag before select rises", v, 8'h00);
            ss_n_i = 1'b1;
            repeat (6) @(negedge clk);
            reg_read(2'd3, v);
            check(req, "flag after slave byte", v, 8'h01);
            reg_read(2'd2, v);
            check(req, "slave received byte", v, pat);
            check(req, "slave transmitted byte", seen, tx);
            reg_write(2'd3, 8'h00);
        end else begin
            ss_n_i = 1'b1;
            repeat (6) @(negedge clk);
            reg_read(2'd3, v);
            check("R12", "no flag on abort", v, 8'h00);
            check("R12", "no irq on abort", irq, 1'b0);
        end
        repeat (H) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_master("R5", 1'b0, 1'b0, 1'b0, 1'b1, 8'd2, 8'hA5, 8'h3C, 1'b0);
        t_master("R6", 1'b1, 1'b1, 1'b1, 1'b1, 8'd0, 8'h96, 8'hE1, 1'b0);
        t_master("R7", 1'b1, 1'b0, 1'b1, 1'b0, 8'd3, 8'hC3, 8'h7E, 1'b0);
        t_master("R2", 1'b0, 1'b1, 1'b0, 1'b1, 8'd4, 8'h5A, 8'h81, 1'b0);
        t_master("R9", 1'b0, 1'b0, 1'b0, 1'b1, 8'd3, 8'h6D, 8'h12, 1'b1);
        t_slave("R10", 1'b0, 1'b0, 1'b0, 8'h4B, 8'hD2, 8);
        t_slave("R11", 1'b1, 1'b1, 1'b1, 8'h27, 8'hB8, 8);
        t_slave("R11", 1'b0, 1'b1, 1'b0, 8'h99, 8'h66, 8);
        t_slave("R12", 1'b0, 1'b0, 1'b0, 8'hF0, 8'h0F, 3);
        t_slave("R12", 1'b1, 1'b0, 1'b0, 8'h3A, 8'hC5, 8);
        t_slave("R12", 1'b0, 1'b1, 1'b1, 8'h11, 8'hEE, 5);
        t_slave("R12", 1'b0, 1'b1, 1'b1, 8'hB4, 8'h2D, 8);
        summary();
    end
endmodule